// File: doc/BRIEF.md
# Programmable-Page Effective Address Generator

This block turns one 12-bit instruction word into the 12-bit effective address it refers to inside a 4K-word field. It reads the 5-bit major opcode in the top bits of the word. Each opcode falls into one of four classes: load/store, arithmetic/logic, jump, or not a memory reference. The class decides whether the word has an indirect bit and a page-select bit. The address is a 5-bit page number followed by the 7-bit in-page offset taken from the low bits of the word.

The page-select bit does not choose between page zero and the current page. It chooses between two page numbers held in a programmable page register inside the block. A flag in that register can redirect the second choice to the current page. While the processor runs a subroutine-entry or subroutine-return sequence, the second choice always means the current page. Jumps always address the current page and ignore the register. The current page is the top five bits of the address of the instruction being decoded.

When indirection is requested, the block makes one read at the direct address through a request/acknowledge memory port. The word it gets back is the effective address. It then presents a one-cycle result: a valid strobe, a memory-reference flag, an indirect flag and the address.

Top module: `pgea_gen`

## Requirements
- R1: After reset, out_valid and mem_req are 0, in_ready is 1, and every page register field is 0, so any page-register-sourced page is page 0.
- R2: For a memory-reference instruction resolved without indirection, out_ea[6:0] equals instr[6:0].
- R3: Opcodes 0 to 7 (instr[11:9] = 000 or 001) are load/store; instr[8] is the indirect bit and instr[7] the page-select bit.
- R4: Opcodes 8 to 23 are arithmetic/logic; they are never indirect, and instr[7] is the page-select bit.
- R5: Opcodes 24 to 27 (instr[11:9] = 110) are jumps; instr[8] is the indirect bit, and the page is always pc[11:7], whatever the page register holds.
- R6: Opcodes 28 to 31 are not memory references; they give out_memref = 0 and out_indirect = 0, make no memory request, and still produce a one-cycle out_valid.
- R7: With page-select 0, the page is page register bits [4:0].
- R8: With page-select 1, page register bit 11 at 0 and sub_mode at 0, the page is page register bits [10:6].
- R9: With page-select 1 and page register bit 11 at 1, the page is pc[11:7].
- R10: With sub_mode at 1, page-select 1 gives pc[11:7] while page-select 0 still gives bits [4:0].
- R11: An indirect request raises mem_req with mem_addr equal to the direct address. Both hold steady until mem_ack. The cycle after the ack edge shows out_valid with out_ea equal to the mem_rdata sampled at that edge and out_indirect = 1.
- R12: A direct instruction accepted at an edge gives out_valid for exactly the following cycle. in_ready is 0 from acceptance until the result cycle has ended.
- R13: A pr_load at an edge stores pr_wdata for instructions accepted at later edges; bit 5 of pr_wdata is reserved and has no effect on any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Block idle and able to accept |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Address of the instruction word |
| sub_mode | input | 1 | Subroutine entry/return sequence active |
| pr_load | input | 1 | Write page register |
| pr_wdata | input | 12 | Page register write value |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 12 | Indirect read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 12 | Read data |
| out_valid | output | 1 | Result strobe, one cycle |
| out_memref | output | 1 | Instruction is a memory reference |
| out_indirect | output | 1 | Address came through an indirect read |
| out_ea | output | 12 | Effective address |

## Verification
A corrupted page register field shows up at once as a wrong upper five bits in out_ea. It appears on the first instruction that selects that field, one cycle after acceptance. A wrong class decode appears either as a spurious or missing mem_req in the cycle after acceptance, or as a page taken from pc instead of the register. A sequencer stuck outside idle holds in_ready low and withholds out_valid, and the bench sees this within the next instruction it issues.

// File: rtl/pgea_pkg.sv
package pgea_pkg;

    localparam int OP_W = 5;

    typedef enum logic [1:0] {
        CL_LDST = 2'd0,
        CL_ALU  = 2'd1,
        CL_JMP  = 2'd2,
        CL_NONE = 2'd3
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      ind;
        logic      psel;
    } dec_s;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } st_e;

    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        if (op < 5'd8)       return CL_LDST;
        else if (op < 5'd24) return CL_ALU;
        else if (op < 5'd28) return CL_JMP;
        else                 return CL_NONE;
    endfunction

endpackage

// File: rtl/pgea_decode.sv
module pgea_decode
    import pgea_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output dec_s            dec
);
    always_comb begin
        dec.cls  = classify(op);
        dec.ind  = 1'b0;
        dec.psel = 1'b0;
        case (dec.cls)
            CL_LDST: begin
                dec.ind  = op[1];
                dec.psel = op[0];
            end
            CL_ALU:  dec.psel = op[0];
            CL_JMP:  dec.ind  = op[1];
            default: ;
        endcase
    end
endmodule

// File: rtl/pgea_pagereg.sv
module pgea_pagereg #(
    parameter int PAGE_W = 5,
    localparam int PR_W  = 2 * PAGE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [PR_W-1:0]   wdata,
    output logic [PAGE_W-1:0] pg_lo,
    output logic [PAGE_W-1:0] pg_hi,
    output logic              use_cur
);
    // layout: [PR_W-1] current-page flag, [PR_W-2 -: PAGE_W] page for select=1,
    // [PAGE_W] reserved, [PAGE_W-1:0] page for select=0
    always_ff @(posedge clk) begin
        if (rst) begin
            pg_lo   <= '0;
            pg_hi   <= '0;
            use_cur <= 1'b0;
        end else if (ld) begin
            pg_lo   <= wdata[PAGE_W-1:0];
            pg_hi   <= wdata[PR_W-2 -: PAGE_W];
            use_cur <= wdata[PR_W-1];
        end
    end

    a_r13_load_visible: assert property (@(posedge clk) disable iff (rst)
        ld |=> (pg_hi == $past(wdata[PR_W-2 -: PAGE_W])) && (use_cur == $past(wdata[PR_W-1])));
endmodule

// File: rtl/pgea_pagesel.sv
module pgea_pagesel
    import pgea_pkg::*;
#(
    parameter int PAGE_W = 5
) (
    input  op_class_e         cls,
    input  logic              psel,
    input  logic              sub_mode,
    input  logic              use_cur,
    input  logic [PAGE_W-1:0] pg_lo,
    input  logic [PAGE_W-1:0] pg_hi,
    input  logic [PAGE_W-1:0] cur_pg,
    output logic [PAGE_W-1:0] page
);
    always_comb begin
        if (cls == CL_JMP)           page = cur_pg;
        else if (!psel)              page = pg_lo;
        else if (sub_mode || use_cur) page = cur_pg;
        else                         page = pg_hi;
    end
endmodule

// File: rtl/pgea_gen.sv
module pgea_gen
    import pgea_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5,
    localparam int OFS_W = ADDR_W - PAGE_W,
    localparam int PR_W  = 2 * PAGE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic              sub_mode,
    input  logic              pr_load,
    input  logic [PR_W-1:0]   pr_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic              out_memref,
    output logic              out_indirect,
    output logic [ADDR_W-1:0] out_ea
);
    dec_s              dec;
    logic [PAGE_W-1:0] pg_lo, pg_hi, page;
    logic              use_cur;
    logic [ADDR_W-1:0] dir_addr, dir_q, ea_q;
    logic              memref_q, ind_q, is_mem, need_ind;
    st_e               st;

    pgea_decode u_dec (
        .op  (instr[ADDR_W-1 -: OP_W]),
        .dec (dec)
    );

    pgea_pagereg #(.PAGE_W(PAGE_W)) u_pr (
        .clk     (clk),
        .rst     (rst),
        .ld      (pr_load),
        .wdata   (pr_wdata),
        .pg_lo   (pg_lo),
        .pg_hi   (pg_hi),
        .use_cur (use_cur)
    );

    pgea_pagesel #(.PAGE_W(PAGE_W)) u_sel (
        .cls      (dec.cls),
        .psel     (dec.psel),
        .sub_mode (sub_mode),
        .use_cur  (use_cur),
        .pg_lo    (pg_lo),
        .pg_hi    (pg_hi),
        .cur_pg   (pc[ADDR_W-1 -: PAGE_W]),
        .page     (page)
    );

    assign dir_addr = {page, instr[OFS_W-1:0]};
    assign is_mem   = (dec.cls != CL_NONE);
    assign need_ind = is_mem && dec.ind;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            dir_q    <= '0;
            ea_q     <= '0;
            memref_q <= 1'b0;
            ind_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (in_valid) begin
                    dir_q    <= dir_addr;
                    ea_q     <= dir_addr;
                    memref_q <= is_mem;
                    ind_q    <= need_ind;
                    st       <= need_ind ? ST_FETCH : ST_DONE;
                end
                ST_FETCH: if (mem_ack) begin
                    ea_q <= mem_rdata;
                    st   <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign in_ready     = (st == ST_IDLE);
    assign mem_req      = (st == ST_FETCH);
    assign mem_addr     = dir_q;
    assign out_valid    = (st == ST_DONE);
    assign out_memref   = memref_q;
    assign out_indirect = ind_q;
    assign out_ea       = ea_q;

    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    a_r11_ack_result: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> out_valid && out_indirect && (out_ea == $past(mem_rdata)));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r4_alu_direct: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (instr[ADDR_W-1 -: OP_W] >= 5'd8) && (instr[ADDR_W-1 -: OP_W] < 5'd24)
        |=> out_valid && !mem_req && !out_indirect);

    a_r5_jump_cur_page: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (instr[ADDR_W-1 -: 3] == 3'b110) && !instr[OFS_W+1]
        |=> out_valid && (out_ea[ADDR_W-1 -: PAGE_W] == $past(pc[ADDR_W-1 -: PAGE_W])));

    a_r6_nonmem: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (instr[ADDR_W-1 -: 3] == 3'b111)
        |=> out_valid && !out_memref && !mem_req);
endmodule

// File: tb/pgea_gen_bench.sv
module pgea_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, sub_mode = 1'b0, pr_load = 1'b0, mem_ack = 1'b0;
    logic [11:0] instr = '0, pc = '0, pr_wdata = '0, mem_rdata = '0;
    logic        in_ready, mem_req, out_valid, out_memref, out_indirect;
    logic [11:0] mem_addr, out_ea;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [11:0] pr_model = '0;

    always #4 clk = ~clk;

    pgea_gen u_pgea_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .pc(pc), .sub_mode(sub_mode), .pr_load(pr_load),
        .pr_wdata(pr_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_memref(out_memref), .out_indirect(out_indirect), .out_ea(out_ea)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected {memref, ind, direct address}
    function automatic logic [13:0] model(input logic [11:0] ins, input logic [11:0] p,
                                          input logic [11:0] pr, input logic sm);
        logic [4:0] op, pg;
        logic mr, ind, ps;
        op = ins[11:7];
        mr = 1'b1; ind = 1'b0; ps = ins[7];
        if (op < 8) ind = ins[8];
        else if (op < 24) ind = 1'b0;
        else if (op < 28) ind = ins[8];
        else mr = 1'b0;
        if (op >= 24 && op < 28) pg = p[11:7];
        else if (!ps) pg = pr[4:0];
        else if (sm || pr[11]) pg = p[11:7];
        else pg = pr[10:6];
        return {mr, ind, pg, ins[6:0]};
    endfunction

    task automatic load_pr(input logic [11:0] v);
        @(negedge clk);
        pr_load = 1'b1; pr_wdata = v;
        @(posedge clk);
        @(negedge clk);
        pr_load = 1'b0;
        pr_model = v;
    endtask

    task automatic issue(input logic [11:0] ins, input logic [11:0] p, input logic sm,
                         input int lat, input logic [11:0] rd, input string tag);
        logic [13:0] e;
        e = model(ins, p, pr_model, sm);
        @(negedge clk);
        chk(in_ready === 1'b1, {tag, " R12 ready"}, {11'd0, in_ready}, 12'd1);
        in_valid = 1'b1; instr = ins; pc = p; sub_mode = sm;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; instr = $urandom; pc = $urandom; sub_mode = $urandom;
        chk(in_ready === 1'b0, {tag, " R12 busy"}, {11'd0, in_ready}, 12'd0);
        if (e[13] && e[12]) begin
            for (int i = 0; i < lat; i++) begin
                chk(mem_req === 1'b1 && mem_addr === e[11:0] && out_valid === 1'b0,
                    {tag, " R11 wait"}, mem_addr, e[11:0]);
                @(posedge clk);
                @(negedge clk);
            end
            chk(mem_req === 1'b1 && mem_addr === e[11:0], {tag, " R11 addr"}, mem_addr, e[11:0]);
            mem_ack = 1'b1; mem_rdata = rd;
            @(posedge clk);
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = $urandom;
            chk(out_valid === 1'b1 && out_ea === rd && out_indirect === 1'b1 && out_memref === 1'b1,
                {tag, " R11 result"}, out_ea, rd);
        end else begin
            chk(out_valid === 1'b1 && mem_req === 1'b0, {tag, " R12 strobe"},
                {10'd0, out_valid, mem_req}, 12'd2);
            chk(out_memref === e[13] && out_indirect === 1'b0, {tag, " R6 flags"},
                {10'd0, out_memref, out_indirect}, {10'd0, e[13], 1'b0});
            if (e[13])
                chk(out_ea === e[11:0], {tag, " R2 address"}, out_ea, e[11:0]);
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, {tag, " R12 pulse end"}, {11'd0, out_valid}, 12'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready === 1'b1 && out_valid === 1'b0 && mem_req === 1'b0, "R1 reset outputs",
            {9'd0, in_ready, out_valid, mem_req}, 12'h4);
        // R1: register cleared, both selects give page 0
        issue(12'b00000_1010101, 12'hFFF, 1'b0, 0, 0, "R1 sel0");
        issue(12'b00001_0011001, 12'hFFF, 1'b0, 0, 0, "R1 sel1");

        // R13: load with reserved bit 5 set; fields lo=3, hi=0x1A, flag=0
        load_pr({1'b0, 5'h1A, 1'b1, 5'h03});
        issue(12'b00000_0000001, 12'h800, 1'b0, 0, 0, "R7 R13 lo page");
        issue(12'b00001_1111111, 12'h800, 1'b0, 0, 0, "R8 hi page");
        issue(12'b01001_0001000, 12'h800, 1'b0, 0, 0, "R4 alu hi page");
        issue(12'b10110_0001000, 12'h800, 1'b0, 0, 0, "R4 alu lo page");
        issue(12'b11000_0100000, 12'hA80, 1'b0, 0, 0, "R5 jump cur page");
        issue(12'b11001_0100000, 12'h080, 1'b0, 0, 0, "R5 jms cur page");
        issue(12'b11100_0000000, 12'h123, 1'b0, 0, 0, "R6 operate");
        issue(12'b11111_1111111, 12'h456, 1'b0, 0, 0, "R6 top opcode");
        issue(12'b00101_0000011, 12'hC00, 1'b1, 0, 0, "R10 sub sel1");
        issue(12'b00100_0000011, 12'hC00, 1'b1, 0, 0, "R10 sub sel0");
        // R9: flag set
        load_pr({1'b1, 5'h1A, 1'b0, 5'h07});
        issue(12'b00001_0000101, 12'h700, 1'b0, 0, 0, "R9 flag cur page");
        issue(12'b00000_0000101, 12'h700, 1'b0, 0, 0, "R9 R7 flag sel0");
        // R3 / R11 indirect with latencies
        issue(12'b00010_0000111, 12'h000, 1'b0, 0, 12'hABC, "R3 R11 ind lat0");
        issue(12'b00111_0000111, 12'h000, 1'b0, 3, 12'h5A5, "R3 R11 ind lat3");
        issue(12'b11010_1111111, 12'hF80, 1'b0, 2, 12'h001, "R5 R11 jump ind");
        issue(12'b01010_0000000, 12'h000, 1'b0, 0, 0, "R4 alu no ind");

        for (int k = 0; k < 400; k++) begin
            if (($urandom % 8) == 0) load_pr($urandom);
            issue($urandom, $urandom, $urandom, $urandom % 4, $urandom, "R2 R3 R7 R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule